// File: doc/BRIEF.md
# Guest Event Exit Arbiter

This block sits between the event sources of a guest execution context and the logic that either enters the guest's own handler or hands control to the hypervisor. On every clock it takes at most one event: an exception (a 5-bit vector, an error code and a flag saying the fault arose while a double fault was being delivered), or an external interrupt request. For that event it decides between two outcomes. The first is an exit to the hypervisor, which carries a reason code. The second is delivery to the guest, which carries the vector. The outcome appears as a one-cycle strobe one clock after the decision.

The hypervisor programs four settings through a small write port:
- a 32-bit per-vector exit bitmap;
- a mask and a match value that qualify page faults (vector 14);
- a control bit that gives ownership of external interrupts to the host.

A guest-owned interrupt that arrives while the guest has interrupts disabled is held inside the block. It is released as soon as the enable flag goes high.

Top module: `vexit_arbiter`

## Requirements
- R1: After reset both strobes are low, no interrupt is pending, and all settings are zero, so every exception is delivered to the guest. This includes a page fault with error code 0.
- R2: For an exception with a vector other than 14, bitmap bit [vector] set gives exit_valid with reason 0 and out_vector = vector. Bit [vector] clear gives deliver_valid with out_vector = vector. Either strobe rises on the clock edge after the one that samples exc_valid.
- R3: For vector 14, let hit = ((pf_err_code & mask) == match). With bitmap bit 14 set the page fault exits when hit is 1. With bit 14 clear it exits when hit is 0. Otherwise it is delivered.
- R4: When dbl_fault_nest is 1 and the exit decision of R2/R3 is "deliver", the outcome is exit reason 2 with out_vector 0. When that decision is "exit", the outcome is exit reason 0, as in R2.
- R5: When the host-ownership control bit is 1, an external interrupt always exits with reason 1 and out_vector = irq_vector, whatever guest_irq_en is.
- R6: When the control bit is 0, an external interrupt never exits. It is delivered with its vector only in a cycle where guest_irq_en is 1.
- R7: A guest-owned interrupt blocked by guest_irq_en = 0 stays pending and produces no strobe. It is resolved in the first cycle in which guest_irq_en is 1, so its strobe appears one clock later.
- R8: An exception takes priority over an interrupt presented in the same cycle. The interrupt is held and resolved on a later cycle.
- R9: exit_valid and deliver_valid are never high together, and each event produces exactly one one-cycle strobe.
- R10: Writes use cfg_sel: 0 = bitmap, 1 = page-fault mask, 2 = page-fault match, 3 = control (bit 0 = host ownership). A write is in effect for events presented in the next cycle.
- R11: An interrupt request that arrives while one is already pending is dropped. The pending vector is kept unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 2 | Setting select (R10 encoding) |
| cfg_wdata | input | 32 | Setting write data |
| exc_valid | input | 1 | Exception present this cycle |
| exc_vector | input | 5 | Exception vector |
| pf_err_code | input | 32 | Page-fault error code |
| dbl_fault_nest | input | 1 | Exception raised while delivering a double fault |
| irq_req | input | 1 | External interrupt request pulse |
| irq_vector | input | 8 | External interrupt vector |
| guest_irq_en | input | 1 | Guest interrupt-enable flag |
| exit_valid | output | 1 | Exit strobe |
| exit_reason | output | 2 | 0 exception, 1 external interrupt, 2 triple fault |
| deliver_valid | output | 1 | Deliver-to-guest strobe |
| out_vector | output | 8 | Vector of the exit or delivery |

## Verification
Some properties are checked by assertions on every cycle:
- the two strobes are mutually exclusive;
- every exception gets an outcome one cycle later;
- reason 1 appears only under host ownership;
- reason 2 appears only after a nested double fault;
- a guest interrupt is delivered only after a cycle with the enable flag high;
- a pending interrupt and its vector hold until accepted.

Other behaviour only the bench scenarios can show. These are the exact bitmap and page-fault mask/match arithmetic over every vector, the release timing of a blocked interrupt, the ordering of an exception against a simultaneous interrupt, and the dropping of a second request.

// File: rtl/vexit_pkg.sv
`timescale 1ns/1ps
package vexit_pkg;
    localparam int EXC_VEC_W = 5;
    localparam int NUM_EXC   = 1 << EXC_VEC_W;
    localparam int VEC_W     = 8;
    localparam int ERR_W     = 32;
    localparam int DATA_W    = 32;
    localparam int PF_VECTOR = 14;

    typedef enum logic [1:0] {
        RSN_EXCEPTION = 2'd0,
        RSN_EXT_IRQ   = 2'd1,
        RSN_TRIPLE    = 2'd2
    } exit_reason_e;

    typedef enum logic [1:0] {
        SEL_BITMAP   = 2'd0,
        SEL_PF_MASK  = 2'd1,
        SEL_PF_MATCH = 2'd2,
        SEL_CTRL     = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [NUM_EXC-1:0] bitmap;
        logic [ERR_W-1:0]   pf_mask;
        logic [ERR_W-1:0]   pf_match;
        logic               host_owns_irq;
    } vexit_cfg_t;

    typedef struct packed {
        logic         do_exit;
        logic         do_deliver;
        exit_reason_e reason;
        logic [VEC_W-1:0] vector;
    } outcome_t;

    // Exit decision for one exception vector, before double-fault escalation.
    function automatic logic exc_exits(input vexit_cfg_t c,
                                       input logic [EXC_VEC_W-1:0] vec,
                                       input logic [ERR_W-1:0] err);
        logic sel_bit;
        logic hit;
        sel_bit = c.bitmap[vec];
        hit     = ((err & c.pf_mask) == c.pf_match);
        if (vec == EXC_VEC_W'(PF_VECTOR))
            return sel_bit ? hit : !hit;
        return sel_bit;
    endfunction
endpackage

// File: rtl/vexit_cfg.sv
`timescale 1ns/1ps
module vexit_cfg
    import vexit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output vexit_cfg_t        cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_BITMAP:   cfg.bitmap        <= wdata[NUM_EXC-1:0];
                SEL_PF_MASK:  cfg.pf_mask       <= wdata[ERR_W-1:0];
                SEL_PF_MATCH: cfg.pf_match      <= wdata[ERR_W-1:0];
                default:      cfg.host_owns_irq <= wdata[0];
            endcase
        end
    end
endmodule

// File: rtl/vexit_irq_hold.sv
`timescale 1ns/1ps
module vexit_irq_hold
    import vexit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [VEC_W-1:0] req_vec,
    input  logic             accept,
    output logic             live,
    output logic [VEC_W-1:0] live_vec
);
    logic             pend_q;
    logic [VEC_W-1:0] vec_q;

    assign live     = pend_q | req;
    assign live_vec = pend_q ? vec_q : req_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            vec_q  <= '0;
        end else if (accept) begin
            pend_q <= 1'b0;
        end else if (req && !pend_q) begin
            pend_q <= 1'b1;
            vec_q  <= req_vec;
        end
    end

    assert_pending_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !accept) |=> pend_q);
    assert_pending_vec_R11: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !accept) |=> $stable(vec_q));
endmodule

// File: rtl/vexit_resolve.sv
`timescale 1ns/1ps
module vexit_resolve
    import vexit_pkg::*;
(
    input  vexit_cfg_t           cfg,
    input  logic                 exc_valid,
    input  logic [EXC_VEC_W-1:0] exc_vec,
    input  logic [ERR_W-1:0]     err,
    input  logic                 dbl_nest,
    input  logic                 irq_live,
    input  logic [VEC_W-1:0]     irq_vec,
    input  logic                 guest_if,
    output outcome_t             res,
    output logic                 irq_accept
);
    logic want_exit;
    assign want_exit = exc_exits(cfg, exc_vec, err);

    always_comb begin
        res        = '0;
        res.reason = RSN_EXCEPTION;
        irq_accept = 1'b0;
        if (exc_valid) begin
            if (dbl_nest && !want_exit) begin
                res.do_exit = 1'b1;
                res.reason  = RSN_TRIPLE;
            end else begin
                res.do_exit    = want_exit;
                res.do_deliver = !want_exit;
                res.vector     = VEC_W'(exc_vec);
            end
        end else if (irq_live) begin
            if (cfg.host_owns_irq) begin
                res.do_exit = 1'b1;
                res.reason  = RSN_EXT_IRQ;
                res.vector  = irq_vec;
                irq_accept  = 1'b1;
            end else if (guest_if) begin
                res.do_deliver = 1'b1;
                res.vector     = irq_vec;
                irq_accept     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vexit_arbiter.sv
`timescale 1ns/1ps
module vexit_arbiter
    import vexit_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    input  logic [DATA_W-1:0]    cfg_wdata,
    input  logic                 exc_valid,
    input  logic [EXC_VEC_W-1:0] exc_vector,
    input  logic [ERR_W-1:0]     pf_err_code,
    input  logic                 dbl_fault_nest,
    input  logic                 irq_req,
    input  logic [VEC_W-1:0]     irq_vector,
    input  logic                 guest_irq_en,
    output logic                 exit_valid,
    output logic [1:0]           exit_reason,
    output logic                 deliver_valid,
    output logic [VEC_W-1:0]     out_vector
);
    vexit_cfg_t       cfg;
    logic             irq_live;
    logic [VEC_W-1:0] irq_live_vec;
    logic             irq_accept;
    outcome_t         res, res_q;

    vexit_cfg u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .cfg(cfg)
    );

    vexit_irq_hold u_hold (
        .clk(clk), .rst(rst), .req(irq_req), .req_vec(irq_vector),
        .accept(irq_accept), .live(irq_live), .live_vec(irq_live_vec)
    );

    vexit_resolve u_res (
        .cfg(cfg), .exc_valid(exc_valid), .exc_vec(exc_vector),
        .err(pf_err_code), .dbl_nest(dbl_fault_nest),
        .irq_live(irq_live), .irq_vec(irq_live_vec),
        .guest_if(guest_irq_en), .res(res), .irq_accept(irq_accept)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q        <= '0;
            res_q.reason <= RSN_EXCEPTION;
        end else begin
            res_q <= res;
        end
    end

    assign exit_valid    = res_q.do_exit;
    assign deliver_valid = res_q.do_deliver;
    assign exit_reason   = res_q.reason;
    assign out_vector    = res_q.vector;

    assert_one_outcome_R9: assert property (@(posedge clk) disable iff (rst)
        !(exit_valid && deliver_valid));
    assert_exc_latency_R2: assert property (@(posedge clk) disable iff (rst)
        $past(exc_valid) |-> (exit_valid || deliver_valid));
    assert_host_owner_R5: assert property (@(posedge clk) disable iff (rst)
        (exit_valid && exit_reason == 2'd1) |-> $past(cfg.host_owns_irq));
    assert_triple_src_R4: assert property (@(posedge clk) disable iff (rst)
        (exit_valid && exit_reason == 2'd2) |-> $past(exc_valid && dbl_fault_nest));
    assert_guest_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (deliver_valid && !$past(exc_valid)) |->
            ($past(guest_irq_en) && !$past(cfg.host_owns_irq)));
endmodule

// File: tb/sim_vexit_arbiter.sv
`timescale 1ns/1ps
module sim_vexit_arbiter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        exc_valid = 1'b0;
    logic [4:0]  exc_vector = '0;
    logic [31:0] pf_err_code = '0;
    logic        dbl_fault_nest = 1'b0;
    logic        irq_req = 1'b0;
    logic [7:0]  irq_vector = '0;
    logic        guest_irq_en = 1'b0;
    logic        exit_valid, deliver_valid;
    logic [1:0]  exit_reason;
    logic [7:0]  out_vector;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_bitmap, m_mask, m_match;

    always #2.5 clk = ~clk;

    vexit_arbiter u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .exc_valid(exc_valid), .exc_vector(exc_vector),
        .pf_err_code(pf_err_code), .dbl_fault_nest(dbl_fault_nest),
        .irq_req(irq_req), .irq_vector(irq_vector), .guest_irq_en(guest_irq_en),
        .exit_valid(exit_valid), .exit_reason(exit_reason),
        .deliver_valid(deliver_valid), .out_vector(out_vector)
    );

    // Packed observation: {exit, deliver, reason, vector}
    function automatic logic [11:0] obs(input logic e, input logic d,
                                        input logic [1:0] r, input logic [7:0] v);
        return {e, d, r, v};
    endfunction

    task automatic check(input string req, input logic [11:0] exp);
        logic [11:0] act;
        act = obs(exit_valid, deliver_valid, exit_reason, out_vector);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got exit=%b dlv=%b rsn=%0d vec=%h, expected exit=%b dlv=%b rsn=%0d vec=%h",
                     req, act[11], act[10], act[9:8], act[7:0],
                     exp[11], exp[10], exp[9:8], exp[7:0]);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Expected outcome from R2, R3, R4
    function automatic logic [11:0] model_exc(input logic [4:0] v, input logic [31:0] e,
                                              input logic dbl);
        logic want;
        want = m_bitmap[v];
        if (v == 5'd14) want = m_bitmap[14] ? ((e & m_mask) == m_match)
                                            : ((e & m_mask) != m_match);
        if (dbl && !want) return obs(1'b1, 1'b0, 2'd2, 8'h00);
        if (want)         return obs(1'b1, 1'b0, 2'd0, {3'b0, v});
        return obs(1'b0, 1'b1, 2'd0, {3'b0, v});
    endfunction

    task automatic exc(input string req, input logic [4:0] v, input logic [31:0] e,
                       input logic dbl);
        @(negedge clk);
        exc_valid = 1'b1; exc_vector = v; pf_err_code = e; dbl_fault_nest = dbl;
        @(negedge clk);
        exc_valid = 1'b0; dbl_fault_nest = 1'b0;
        check(req, model_exc(v, e, dbl));
    endtask

    localparam logic [11:0] NONE = 12'h000;

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_bitmap = '0; m_mask = '0; m_match = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", NONE);
        exc("R1 zero bitmap delivers", 5'd3, 32'h0, 1'b0);
        exc("R1 zero pf settings deliver page fault", 5'd14, 32'h0, 1'b0);

        // Sweep: bitmap patterns x all vectors x two error codes x nesting (R2 R3 R4 R10)
        wr(2'd1, 32'h0000_000F); m_mask = 32'h0000_000F;
        wr(2'd2, 32'h0000_0005); m_match = 32'h0000_0005;
        for (int p = 0; p < 4; p++) begin
            logic [31:0] bm;
            case (p)
                0: bm = 32'hFFFF_FFFF;
                1: bm = 32'hA5A5_5A5A;
                2: bm = 32'h0000_4001;
                default: bm = 32'hFFFF_BFFE;
            endcase
            wr(2'd0, bm); m_bitmap = bm;
            for (int v = 0; v < 32; v++)
                for (int k = 0; k < 2; k++)
                    for (int d = 0; d < 2; d++)
                        exc(v == 14 ? "R3 page fault qualify" : (d == 1 ? "R4 nested fault" : "R2 bitmap sweep"),
                            5'(v), k == 0 ? 32'h0000_0105 : 32'h0000_0106, d[0]);
        end

        // Host-owned interrupts (R5)
        wr(2'd3, 32'h1);
        for (int g = 0; g < 2; g++) begin
            @(negedge clk);
            guest_irq_en = g[0]; irq_req = 1'b1; irq_vector = 8'h20 + 8'(g);
            @(negedge clk);
            irq_req = 1'b0;
            check("R5 host irq exits", obs(1'b1, 1'b0, 2'd1, 8'h20 + 8'(g)));
            @(negedge clk);
            check("R9 single strobe", NONE);
        end

        // Priority: exception and interrupt together (R8)
        m_bitmap = 32'hFFFF_BFFE;
        @(negedge clk);
        exc_valid = 1'b1; exc_vector = 5'd6; pf_err_code = '0;
        irq_req = 1'b1; irq_vector = 8'h33;
        @(negedge clk);
        exc_valid = 1'b0; irq_req = 1'b0;
        check("R8 exception first", model_exc(5'd6, 32'h0, 1'b0));
        @(negedge clk);
        check("R8 held irq next", obs(1'b1, 1'b0, 2'd1, 8'h33));

        // Guest-owned interrupts (R6 R7 R11)
        wr(2'd3, 32'h0);
        @(negedge clk);
        guest_irq_en = 1'b1; irq_req = 1'b1; irq_vector = 8'h41;
        @(negedge clk);
        irq_req = 1'b0;
        check("R6 guest irq delivered", obs(1'b0, 1'b1, 2'd0, 8'h41));
        @(negedge clk);
        guest_irq_en = 1'b0; irq_req = 1'b1; irq_vector = 8'h50;
        @(negedge clk);
        irq_req = 1'b1; irq_vector = 8'h51;
        check("R6 blocked irq no strobe", NONE);
        @(negedge clk);
        irq_req = 1'b0;
        check("R7 still pending", NONE);
        @(negedge clk);
        check("R7 still pending", NONE);
        guest_irq_en = 1'b1;
        @(negedge clk);
        check("R7 released with first vector R11", obs(1'b0, 1'b1, 2'd0, 8'h50));
        @(negedge clk);
        check("R11 second request dropped", NONE);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule